// File: doc/BRIEF.md
# Software Interrupt Pending Bank

A bank of per-hart software-interrupt pending flags reached through a simple memory-mapped request port. Each hart owns one 32-bit word. Bit 0 of that word is the pending flag, and the flag drives that hart's level interrupt output directly. The `MODE` parameter fixes the behaviour when the bank is built. In machine mode, software raises, lowers and reads back each flag. In supervisor mode, a write can only raise a flag, every read returns zero, and the receiving core lowers the flag itself by pulsing its clear input once it has taken the interrupt.

Each hart's flag is a two-state machine. The states are QUIET (output low) and RAISED (output high). The transitions are:

- SET, from QUIET to RAISED, on a write with bit 0 = 1.
- DROP, from RAISED to QUIET. In machine mode this is a write with bit 0 = 0. In supervisor mode it is a core clear pulse with no SET in the same cycle.
- HOLD, staying in the current state, in every other cycle.

Read responses come from a one-stage response register.

Top module: `swi_bank`

## Requirements
- R1: The word for hart i sits at byte offset 4*i, for i below NUM_HARTS. A request whose address has bits 1:0 not equal to 00, or whose offset is at or beyond 4*NUM_HARTS, reads as zero and changes no flag.
- R2: A write with bit 0 = 1 raises that hart's pending flag. The hart's `sw_irq` bit is high from the clock edge that takes the write.
- R3: In machine mode, a write with bit 0 = 0 lowers that hart's flag at the clock edge that takes the write.
- R4: In supervisor mode, a write with bit 0 = 0 leaves the flag unchanged.
- R5: In machine mode, a read returns the hart's flag in bit 0. Bits 31:1 of every response are zero, and bits 31:1 of write data have no effect.
- R6: In supervisor mode, every read returns zero.
- R7: In supervisor mode, `core_clr[i]` lowers only hart i's flag. If a raising write to hart i falls in the same cycle, the flag stays raised.
- R8: In machine mode, `core_clr` has no effect on any flag.
- R9: `bus_rvalid` is high in the cycle after a read request (`bus_req`=1, `bus_we`=0), with `bus_rdata` valid in that cycle. `bus_rdata` is zero whenever `bus_rvalid` is low.
- R10: Reset lowers every flag and `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_req | input | 1 | Request strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the bank |
| bus_wdata | input | 32 | Write data; only bit 0 is used |
| bus_rvalid | output | 1 | Read response valid |
| bus_rdata | output | 32 | Read response data |
| core_clr | input | NUM_HARTS | Per-hart clear from the core (supervisor mode) |
| sw_irq | output | NUM_HARTS | Per-hart software interrupt level |

## Verification
Two events can land on the same hart in one cycle: a raising write and a core clear pulse. In supervisor mode this is the only SET/DROP conflict, and the raise must win. In machine mode the same clear pulse must be ignored, even when it coincides with a lowering write.

The bench provokes both cases by driving `core_clr` in the same cycle as the bus write to a machine-mode and a supervisor-mode instance that share one bus. At the next sample it compares each `sw_irq` vector against a model in which the clear is applied before the set.

// File: rtl/swi_pkg.sv
package swi_pkg;
    localparam int unsigned WORD_W = 32;

    typedef enum logic {
        MODE_MACHINE    = 1'b0,
        MODE_SUPERVISOR = 1'b1
    } swi_mode_e;

    typedef enum logic {
        CELL_QUIET  = 1'b0,
        CELL_RAISED = 1'b1
    } cell_state_e;
endpackage

// File: rtl/swi_decode.sv
module swi_decode #(
    parameter int unsigned NUM_HARTS = 4,
    parameter int unsigned ADDR_W    = 6
) (
    input  logic                 req,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wbit,
    output logic [NUM_HARTS-1:0] sel,
    output logic [NUM_HARTS-1:0] set_vec,
    output logic [NUM_HARTS-1:0] wzero_vec,
    output logic                 rd_req
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic             aligned;
    logic [IDX_W-1:0] idx;

    assign aligned = (addr[1:0] == 2'b00);
    assign idx     = addr[ADDR_W-1:2];

    for (genvar i = 0; i < NUM_HARTS; i++) begin : g_sel
        assign sel[i]       = req && aligned && (idx == IDX_W'(i));
        assign set_vec[i]   = sel[i] && we && wbit;
        assign wzero_vec[i] = sel[i] && we && !wbit;
    end

    assign rd_req = req && !we;
endmodule

// File: rtl/swi_cell.sv
module swi_cell
    import swi_pkg::*;
#(
    parameter swi_mode_e MODE = MODE_MACHINE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wzero_i,
    input  logic core_clr_i,
    output logic irq_o
);
    cell_state_e state_q, state_d;
    logic        drop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CELL_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        drop    = (MODE == MODE_MACHINE) ? wzero_i : core_clr_i;
        state_d = state_q;
        unique case (state_q)
            CELL_QUIET:  if (set_i)          state_d = CELL_RAISED;
            CELL_RAISED: if (drop && !set_i) state_d = CELL_QUIET;
            default:                         state_d = CELL_QUIET;
        endcase
    end

    always_comb begin
        irq_o = (state_q == CELL_RAISED);
    end

    a_r2_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> irq_o);
    a_r3_machine_zero_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == MODE_MACHINE && wzero_i) |=> !irq_o);
    a_r4_super_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == MODE_SUPERVISOR && wzero_i && !core_clr_i && irq_o) |=> irq_o);
    a_r7_core_clear_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == MODE_SUPERVISOR && core_clr_i && !set_i) |=> !irq_o);
    a_r8_machine_clr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == MODE_MACHINE && core_clr_i && !wzero_i && irq_o) |=> irq_o);
endmodule

// File: rtl/swi_rsp.sv
module swi_rsp
    import swi_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4,
    parameter swi_mode_e   MODE      = MODE_MACHINE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_req,
    input  logic [NUM_HARTS-1:0] sel,
    input  logic [NUM_HARTS-1:0] pend,
    output logic                 rvalid,
    output logic [WORD_W-1:0]    rdata
);
    logic [WORD_W-1:0] rdata_d;

    always_comb begin
        rdata_d = '0;
        if (rd_req && MODE == MODE_MACHINE)
            rdata_d = {{(WORD_W-1){1'b0}}, |(sel & pend)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_req;
            rdata  <= rdata_d;
        end
    end

    a_r9_rvalid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rvalid);
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0));
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[WORD_W-1:1] == '0);
    a_r6_super_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (MODE == MODE_SUPERVISOR && rvalid) |-> (rdata == '0));
endmodule

// File: rtl/swi_bank.sv
module swi_bank
    import swi_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4,
    parameter int unsigned ADDR_W    = 6,
    parameter swi_mode_e   MODE      = MODE_MACHINE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic                 bus_rvalid,
    output logic [31:0]          bus_rdata,
    input  logic [NUM_HARTS-1:0] core_clr,
    output logic [NUM_HARTS-1:0] sw_irq
);
    logic [NUM_HARTS-1:0] sel, set_vec, wzero_vec;
    logic                 rd_req;
    logic                 unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[WORD_W-1:1];

    swi_decode #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W)) u_decode (
        .req       (bus_req),
        .we        (bus_we),
        .addr      (bus_addr),
        .wbit      (bus_wdata[0]),
        .sel       (sel),
        .set_vec   (set_vec),
        .wzero_vec (wzero_vec),
        .rd_req    (rd_req)
    );

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        swi_cell #(.MODE(MODE)) u_cell (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (set_vec[h]),
            .wzero_i    (wzero_vec[h]),
            .core_clr_i (core_clr[h]),
            .irq_o      (sw_irq[h])
        );
    end

    swi_rsp #(.NUM_HARTS(NUM_HARTS), .MODE(MODE)) u_rsp (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_req (rd_req),
        .sel    (sel),
        .pend   (sw_irq),
        .rvalid (bus_rvalid),
        .rdata  (bus_rdata)
    );

    a_r1_misaligned_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr[1:0] != 2'b00 && core_clr == '0)
        |=> (sw_irq == $past(sw_irq)));
endmodule

// File: tb/sim_swi_bank.sv
`timescale 1ns/1ps
module sim_swi_bank;
    import swi_pkg::*;

    localparam int N = 4;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0, we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wdata = '0;
    logic [N-1:0]  clr_m = '0, clr_s = '0;
    logic          rv_m, rv_s;
    logic [31:0]   rd_m, rd_s;
    logic [N-1:0]  irq_m, irq_s;
    logic [N-1:0]  exp_m = '0, exp_s = '0;
    int            checks = 0, fails = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    swi_bank #(.NUM_HARTS(N), .ADDR_W(AW), .MODE(MODE_MACHINE)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rvalid(rv_m), .bus_rdata(rd_m),
        .core_clr(clr_m), .sw_irq(irq_m));

    swi_bank #(.NUM_HARTS(N), .ADDR_W(AW), .MODE(MODE_SUPERVISOR)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_req(req), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rvalid(rv_s), .bus_rdata(rd_s),
        .core_clr(clr_s), .sw_irq(irq_s));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit in_range(input logic [AW-1:0] a);
        return (a[1:0] == 2'b00) && (int'(a[AW-1:2]) < N);
    endfunction

    // Write with optional same-cycle core clears; model applies clear before set.
    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [N-1:0] cm);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a; wdata = d; clr_m = cm; clr_s = cm;
        @(negedge clk);
        req = 1'b0; we = 1'b0; clr_m = '0; clr_s = '0;
        exp_s &= ~cm;                                  // R7 clear, R8 machine ignores
        if (in_range(a)) begin
            if (d[0]) begin
                exp_m[a[AW-1:2]] = 1'b1;
                exp_s[a[AW-1:2]] = 1'b1;
            end else begin
                exp_m[a[AW-1:2]] = 1'b0;               // R3; R4 keeps supervisor flag
            end
        end
        chk(in_range(a) ? "R2 R3 R8 machine irq" : "R1 machine irq", 32'(irq_m), 32'(exp_m));
        chk(in_range(a) ? "R2 R4 R7 supervisor irq" : "R1 supervisor irq", 32'(irq_s), 32'(exp_s));
    endtask

    task automatic rd(input logic [AW-1:0] a);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
        chk("R9 rvalid machine", 32'(rv_m), 32'd1);
        chk("R9 rvalid supervisor", 32'(rv_s), 32'd1);
        chk(in_range(a) ? "R5 machine read" : "R1 machine read", rd_m,
            in_range(a) ? {31'b0, exp_m[a[AW-1:2]]} : 32'd0);
        chk("R6 supervisor read", rd_s, 32'd0);
    endtask

    task automatic core_pulse(input logic [N-1:0] m);
        @(negedge clk);
        clr_m = m; clr_s = m;
        @(negedge clk);
        clr_m = '0; clr_s = '0;
        exp_s &= ~m;
        chk("R7 core clear", 32'(irq_s), 32'(exp_s));
        chk("R8 core clear ignored", 32'(irq_m), 32'(exp_m));
        chk("R9 idle rdata", rd_m | rd_s, 32'd0);
    endtask

    initial begin
        logic [31:0] pats [4];
        pats[0] = 32'h0000_0001; pats[1] = 32'hFFFF_FFFE;
        pats[2] = 32'h0000_0003; pats[3] = 32'h0000_0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset irq", 32'({irq_m, irq_s}), 32'd0);
        chk("R10 reset rvalid", 32'({rv_m, rv_s}), 32'd0);
        rd(0);

        for (int a = 0; a < (1 << AW); a++) begin
            for (int p = 0; p < 4; p++) begin
                wr(AW'(a), pats[p], '0);
                rd(AW'(a));
                rd(AW'((a & 12)));
                if (p == 2) core_pulse(N'(1 << (a & 3)));
            end
            if ((a % 16) == 15) core_pulse('1);
        end

        // Same-cycle conflicts: set vs core clear (R7), machine clear vs ignored pulse (R8)
        for (int h = 0; h < N; h++) wr(AW'(h * 4), 32'd1, '0);
        wr(AW'(8), 32'd1, 4'b0110);
        chk("R7 set wins hart2", 32'(irq_s[2]), 32'd1);
        chk("R7 clear hits hart1 only", 32'(irq_s), 32'b1101);
        wr(AW'(4), 32'd0, 4'b1001);
        chk("R8 machine flags", 32'(irq_m), 32'b1101);
        for (int h = 0; h < N; h++) rd(AW'(h * 4));

        // Reset with flags raised
        for (int h = 0; h < N; h++) wr(AW'(h * 4), 32'd1, '0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R10 reset clears machine", 32'(irq_m), 32'd0);
        chk("R10 reset clears supervisor", 32'(irq_s), 32'd0);
        exp_m = '0; exp_s = '0;
        rst_n = 1'b1;
        rd(AW'(4));

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog R9 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule